// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block keeps time in a slow 32.768 kHz domain and is controlled from a 32-bit register bus in the system clock domain. A 47-bit counter advances once per slow tick. Its upper 32 bits count whole seconds and its lower 15 bits count ticks within the current second. The counter value appears in the bus domain through a stable-sample crossing: the bus side takes a new value only when two consecutive synchronised samples agree. Software still reads the two halves twice and retries until both reads match.

The run, alarm-enable and wakeup-enable requests pass through a synchroniser into the slow domain and come back again. The control register therefore reports the state the slow side has actually taken, and software polls it after every change. A bus-side state machine follows the run handshake.

- `ST_OFF`: fully stopped. Counter writes are accepted here.
- `ST_ARMING`: run requested, not yet confirmed. It moves to `ST_RUNNING` when the echo rises. It returns to `ST_OFF` if the request drops while the echo is still low.
- `ST_RUNNING`: confirmed running. It moves to `ST_DISARMING` when the request drops.
- `ST_DISARMING`: stop requested. It moves to `ST_OFF` when the echo falls.

A counter value written in `ST_OFF` is kept in a shadow and marked pending. The slow side loads it on the next start. The pending mark clears on the `ST_ARMING` to `ST_RUNNING` transition.

A seconds alarm sets a sticky flag, and the flag drives an interrupt and a wakeup output. A free 32-bit word is provided for glitch-detect initialisation.

Top module: `rtc_lp_counter`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped, and `irq` and `wakeup` are 0.
- R2: The register offsets are: control 0x04, status 0x18, counter high 0x1C, counter low 0x20, alarm 0x24 and glitch word 0x30. The alarm and glitch words read back exactly what was last written. Any other offset reads 0.
- R3: The counter advances by one per slow tick and the carry crosses from the low half into the high half. Counter low returns counter bits [31:0]. Counter high returns bits [46:32] in bits [14:0], with bits [31:15] reading 0. Whole seconds are bits [46:15].
- R4: Control bit 0 is run, bit 1 is alarm enable and bit 3 is wakeup enable. On read, these bits return the synchronised state, so a set bit reads 0 in the cycle after the write and reads 1 within 20 slow periods. All other control bits read 0.
- R5: Counter writes are taken only while the block is fully stopped (`ST_OFF`). A taken value is not visible before the next start and becomes the counter value at that start. Counter writes while running are ignored.
- R6: A stopped counter holds its value. A restart with no new counter write continues from the held value.
- R7: Status bit 0 sets when the seconds value becomes equal to the alarm word while the synchronised alarm enable is 1. It does not set while the alarm enable is 0.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R9: `irq` equals the flag AND the synchronised alarm enable. `wakeup` equals `irq` AND the synchronised wakeup enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |
| wakeup | output | 1 | Alarm wakeup request |

## Verification
Register and status reads are combinational, so they are sampled in the same bus cycle, on the falling edge after the address is driven. Enable changes are due between two and about six slow periods after the write. The bench never samples them at a fixed cycle: it polls control until the expected value appears, and only then checks `irq`, `wakeup` and the counter. A counter change needs about four bus cycles after a slow edge to reach the bus side. Counter values are therefore read only after the counter has been stopped and some slow periods have passed. Tick counts that depend on polling time are checked against a range, not an exact value.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMING,
        ST_RUNNING,
        ST_DISARMING
    } run_state_e;

    // Register byte offsets
    localparam int OFS_CTRL   = 'h04;
    localparam int OFS_STAT   = 'h18;
    localparam int OFS_CNT_HI = 'h1C;
    localparam int OFS_CNT_LO = 'h20;
    localparam int OFS_ALARM  = 'h24;
    localparam int OFS_GLITCH = 'h30;

    // Control and status bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_ALM  = 1;
    localparam int CTL_WAKE = 3;
    localparam int STAT_ALM = 0;

endpackage

// File: rtl/rtc_sync_bits.sv
module rtc_sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core #(
    parameter int CNT_W = 47
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             run_s,
    input  logic             load_s,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    logic run_q;

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt   <= '0;
        end else begin
            run_q <= run_s;
            if (run_s && !run_q && load_s) cnt <= load_val;
            else if (run_s)                cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rtc_cnt_xfer.sv
module rtc_cnt_xfer #(
    parameter int W      = 47,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] view
);
    logic [W-1:0] smp;
    logic [W-1:0] smp_prev;

    rtc_sync_bits #(.W(W), .STAGES(STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .d(src), .q(smp)
    );

    // Take a sample only once two consecutive ones agree
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_prev <= '0;
            view     <= '0;
        end else begin
            smp_prev <= smp;
            if (smp == smp_prev) view <= smp;
        end
    end
endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter
    import rtc_lp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 47,
    parameter int FRAC_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wakeup
);
    localparam int SEC_W = CNT_W - FRAC_W;
    localparam int HI_W  = CNT_W - DATA_W;

    run_state_e st_q, st_d;

    logic run_req, alm_req, wake_req, load_pend;
    logic [CNT_W-1:0]  shadow;
    logic [SEC_W-1:0]  alarm_q;
    logic [DATA_W-1:0] glitch_q;
    logic flag, hit, hit_q;
    logic cnt_wr_ok, load_taken;

    logic [3:0] req_s;
    logic [2:0] echo;
    logic run_e, alm_e, wake_e;
    logic [CNT_W-1:0] slow_cnt, view;

    logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_glitch, clr_alarm;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_hi     = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign wr_lo     = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign wr_alarm  = bus_wr && (bus_addr == ADDR_W'(OFS_ALARM));
    assign wr_glitch = bus_wr && (bus_addr == ADDR_W'(OFS_GLITCH));
    assign clr_alarm = wr_stat && bus_wdata[STAT_ALM];

    // Bus to slow: requests and load marker
    rtc_sync_bits #(.W(4), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n),
        .d({load_pend, wake_req, alm_req, run_req}), .q(req_s)
    );

    rtc_slow_core #(.CNT_W(CNT_W)) u_core (
        .slow_clk(slow_clk), .rst_n(rst_n),
        .run_s(req_s[0]), .load_s(req_s[3]), .load_val(shadow),
        .cnt(slow_cnt)
    );

    // Slow to bus: state actually taken
    rtc_sync_bits #(.W(3), .STAGES(SYNC_STAGES)) u_echo_sync (
        .clk(clk), .rst_n(rst_n), .d(req_s[2:0]), .q(echo)
    );
    assign {wake_e, alm_e, run_e} = echo;

    rtc_cnt_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_xfer (
        .clk(clk), .rst_n(rst_n), .src(slow_cnt), .view(view)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:       if (run_req) st_d = ST_ARMING;
            ST_ARMING:    if (run_e) st_d = ST_RUNNING;
                          else if (!run_req) st_d = ST_OFF;
            ST_RUNNING:   if (!run_req) st_d = ST_DISARMING;
            ST_DISARMING: if (!run_e) st_d = ST_OFF;
            default:      st_d = ST_OFF;
        endcase
    end

    // State outputs
    always_comb begin
        cnt_wr_ok  = 1'b0;
        load_taken = 1'b0;
        unique case (st_q)
            ST_OFF:       cnt_wr_ok  = 1'b1;
            ST_ARMING:    load_taken = run_e;
            ST_RUNNING:   ;
            ST_DISARMING: ;
            default:      ;
        endcase
    end

    // Registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_req   <= 1'b0;
            alm_req   <= 1'b0;
            wake_req  <= 1'b0;
            load_pend <= 1'b0;
            shadow    <= '0;
            alarm_q   <= '0;
            glitch_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_req  <= bus_wdata[CTL_RUN];
                alm_req  <= bus_wdata[CTL_ALM];
                wake_req <= bus_wdata[CTL_WAKE];
            end
            if (wr_lo && cnt_wr_ok) shadow[DATA_W-1:0]     <= bus_wdata;
            if (wr_hi && cnt_wr_ok) shadow[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
            if ((wr_lo || wr_hi) && cnt_wr_ok) load_pend <= 1'b1;
            else if (load_taken)               load_pend <= 1'b0;
            if (wr_alarm)  alarm_q  <= bus_wdata[SEC_W-1:0];
            if (wr_glitch) glitch_q <= bus_wdata;
        end
    end

    // Alarm match, set on entry into a match
    assign hit = alm_e && (view[CNT_W-1:FRAC_W] == alarm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            hit_q <= hit;
            if (hit && !hit_q)  flag <= 1'b1;
            else if (clr_alarm) flag <= 1'b0;
        end
    end

    assign irq    = flag && alm_e;
    assign wakeup = irq && wake_e;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CTL_RUN]  = run_e;
                bus_rdata[CTL_ALM]  = alm_e;
                bus_rdata[CTL_WAKE] = wake_e;
            end
            ADDR_W'(OFS_STAT):   bus_rdata[STAT_ALM] = flag;
            ADDR_W'(OFS_CNT_HI): bus_rdata[HI_W-1:0] = view[CNT_W-1:DATA_W];
            ADDR_W'(OFS_CNT_LO): bus_rdata = view[DATA_W-1:0];
            ADDR_W'(OFS_ALARM):  bus_rdata[SEC_W-1:0] = alarm_q;
            ADDR_W'(OFS_GLITCH): bus_rdata = glitch_q;
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_lp_checker.sv
module rtc_lp_checker #(
    parameter int SEC_W = 32,
    parameter int CNT_W = 47
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             wakeup,
    input logic             flag,
    input logic             hit,
    input logic             clr_alarm,
    input logic             alm_e,
    input logic [SEC_W-1:0] sec_view,
    input logic [SEC_W-1:0] alarm_q,
    input logic             cnt_wr_ok,
    input logic [CNT_W-1:0] shadow
);
    p_wake_needs_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> irq);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && alm_e));

    p_flag_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(alm_e && (sec_view == alarm_q)));

    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_alarm && !hit) |=> !flag);

    p_shadow_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_ok |=> $stable(shadow));
endmodule

bind rtc_lp_counter rtc_lp_checker #(.SEC_W(SEC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .wakeup(wakeup), .flag(flag),
    .hit(hit), .clr_alarm(clr_alarm), .alm_e(alm_e),
    .sec_view(view[CNT_W-1:FRAC_W]), .alarm_q(alarm_q),
    .cnt_wr_ok(cnt_wr_ok), .shadow(shadow)
);

// File: tb/rtc_lp_counter_tb.sv
module rtc_lp_counter_tb;
    logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, wakeup;

    always #10 clk = ~clk;
    initial begin
        #7;
        forever #100 slow_clk = ~slow_clk;
    end

    rtc_lp_counter u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wakeup(wakeup)
    );

    localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                           A_LO = 8'h20, A_ALARM = 8'h24, A_GLITCH = 8'h30;

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 wakeup
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic chk_req = 1'b0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Monitor
    always @(negedge clk) begin
        if (chk_req) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                1:       act = {31'b0, irq};
                2:       act = {31'b0, wakeup};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic push(input int k, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic own_check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_ctrl(input logic [31:0] e, input string tag);
        logic [31:0] v;
        v = '0;
        for (int n = 0; n < 400; n++) begin
            peek(A_CTRL, v);
            if (v == e) break;
        end
        own_check(v == e, tag, v, e);
    endtask

    task automatic slow_wait(input int n);
        repeat (n * 10) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, frac1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        slow_wait(4);

        // R1 reset state
        push(0, A_CTRL, 32'h0, "R1 ctrl");
        push(0, A_STAT, 32'h0, "R1 status");
        push(0, A_LO, 32'h0, "R1 cnt lo");
        push(0, A_HI, 32'h0, "R1 cnt hi");
        push(0, A_ALARM, 32'h0, "R1 alarm");
        push(1, A_CTRL, 32'h0, "R1 irq");
        push(2, A_CTRL, 32'h0, "R1 wakeup");

        // R2 glitch word and alarm word, unmapped offset
        wr(A_GLITCH, 32'h41736166);
        push(0, A_GLITCH, 32'h41736166, "R2 glitch word");
        wr(A_ALARM, 32'h0004_0000);
        push(0, A_ALARM, 32'h0004_0000, "R2 alarm word");
        push(0, 8'h08, 32'h0, "R2 unmapped");

        // R5 load while stopped: seconds 0x3FFFF, ticks 0x7FF0
        wr(A_LO, 32'hFFFF_FFF0);
        wr(A_HI, 32'h0000_0001);
        slow_wait(5);
        push(0, A_LO, 32'h0, "R5 load not visible before start");

        // R4 start with alarm and wakeup enables
        wr(A_CTRL, 32'h0000_000B);
        push(0, A_CTRL, 32'h0, "R4 readback lags write");
        wait_ctrl(32'h0000_000B, "R4 readback settles");
        push(0, A_STAT, 32'h0, "R7 no flag before match");

        // R5 write while running is ignored
        wr(A_LO, 32'h0);
        slow_wait(40);

        // R7 R9 alarm hit, irq and wakeup
        push(0, A_STAT, 32'h1, "R7 flag set on match");
        push(1, A_CTRL, 32'h1, "R9 irq asserted");
        push(2, A_CTRL, 32'h1, "R9 wakeup asserted");

        wr(A_CTRL, 32'h0000_0003);
        wait_ctrl(32'h0000_0003, "R4 wake enable off");
        push(2, A_CTRL, 32'h0, "R9 wakeup gated");
        push(1, A_CTRL, 32'h1, "R9 irq kept");

        wr(A_CTRL, 32'h0);
        wait_ctrl(32'h0, "R4 stop settles");
        push(1, A_CTRL, 32'h0, "R9 irq gated by alarm enable");
        push(0, A_STAT, 32'h1, "R8 flag sticky");
        slow_wait(6);

        // R3 carry into high half, ticks within range
        push(0, A_HI, 32'h2, "R3 carry into high half");
        peek(A_LO, v);
        own_check(v[31:15] == 17'h0, "R3 seconds low bits", {15'b0, v[31:15]}, 32'h0);
        own_check(v[14:0] >= 15'h10 && v[14:0] <= 15'h80, "R3 tick count", {17'b0, v[14:0]}, 32'h30);
        frac1 = {17'b0, v[14:0]};

        // R6 hold while stopped
        slow_wait(10);
        push(0, A_LO, v, "R6 stopped counter holds");

        // R8 write-one-to-clear
        wr(A_STAT, 32'h0);
        push(0, A_STAT, 32'h1, "R8 write 0 no effect");
        wr(A_STAT, 32'h1);
        push(0, A_STAT, 32'h0, "R8 write 1 clears");

        // R6 restart without load continues; R7 no flag with alarm disabled
        wr(A_CTRL, 32'h1);
        wait_ctrl(32'h1, "R4 restart settles");
        slow_wait(10);
        wr(A_CTRL, 32'h0);
        wait_ctrl(32'h0, "R4 second stop");
        slow_wait(6);
        push(0, A_HI, 32'h2, "R6 high half continues");
        peek(A_LO, v);
        own_check(v[31:15] == 17'h0 && {17'b0, v[14:0]} > frac1 + 5,
                  "R6 continues from held value", v, frac1 + 10);
        push(0, A_STAT, 32'h0, "R7 no flag while alarm disabled");
        push(1, A_CTRL, 32'h0, "R9 irq low");

        done = 1'b1;
        finish_run();
    end
endmodule